// File: doc/BRIEF.md
# Line Write Queue with Read Forwarding

This block sits between a single request path and a cache data array, and it owns that array. Ordinary cache traffic and maintenance accesses both use this path. No input tells them apart, so both see the same queueing and forwarding.

A write arrives in two steps. First its address is presented on the request port. Later the whole line is presented on the data port. The line then waits in a small queue for a fixed number of cycles before it is committed to the array. A read that names a line still waiting in the queue gets the queued copy and raises a flag saying so. A read that arrives after that line has been committed gets the copy from the array.

Writes always replace all 32 bytes of a line. A requester that means to change fewer bytes therefore overwrites the rest with whatever it put on the other lanes.

Top module: `line_wq_bypass`

## Requirements
- R1: After reset the queue holds no lines, `req_ready` is 1 and `rd_valid` is 0.
- R2: A write address is accepted on a cycle where `req_valid`=1, `req_write`=1 and `req_ready`=1. From then on `req_ready` stays 0 until the next cycle with `dat_valid`=1. That cycle supplies the full line for the accepted address.
- R3: `dat_valid` on a cycle with no accepted address waiting for its data has no effect, and no line anywhere changes.
- R4: A read (`req_valid`=1, `req_write`=0) gives `rd_valid`=1 with `rd_data` and `rd_bypass` exactly one cycle later. `rd_valid` is 0 in every other cycle.
- R5: A read sampled 1 to WINDOW cycles after the data phase of a write to the same line returns that queued line with `rd_bypass`=1.
- R6: A read sampled more than WINDOW cycles after a write's data phase returns the line from the array with `rd_bypass`=0, and the array holds the written data.
- R7: Two kinds of read see the array contents from before the write: a read sampled in the same cycle as the write's data phase, and a read sampled while that write's address still waits for its data.
- R8: When several queued lines match a read, the one whose data phase came last is returned.
- R9: Matching and array indexing use line addresses, which are `req_addr` bits [ADDR_W-1:5]. The low 5 byte-offset bits are ignored.
- R10: While DEPTH lines are queued, `req_ready` is 0, and a write address offered then is dropped.
- R11: All 256 data bits of a write are stored and later returned, from the queue or from the array, with no byte masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write address phase, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_ready | output | 1 | A write address can be taken |
| dat_valid | input | 1 | Data phase of the waiting write |
| dat_line | input | 256 | Full line for the waiting write |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 256 | Read response line |
| rd_bypass | output | 1 | 1 = response came from the queue |

## Verification
The bench builds the block with ADDR_W=10, WINDOW=6 and DEPTH=3. That gives 32 lines, and it lets every line be loaded up front so that each read has a known expected value. With WINDOW at six and DEPTH at three, three back-to-back writes fill the queue, so the path that refuses a write address can be reached. The window edge is probed one cycle at a time on both sides of WINDOW. A random mix of reads and writes, confined to a few lines, then produces frequent same-line matches and several matches at once.

// File: rtl/line_wq_bypass.sv
`timescale 1ns/1ps
module line_wq_bypass #(
  parameter int ADDR_W     = 10,
  parameter int LINE_BYTES = 32,
  parameter int DEPTH      = 4,
  parameter int WINDOW     = 6
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    req_ready,
  input  logic                    dat_valid,
  input  logic [LINE_BYTES*8-1:0] dat_line,
  output logic                    rd_valid,
  output logic [LINE_BYTES*8-1:0] rd_data,
  output logic                    rd_bypass
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFF    = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - OFF;
  localparam int NLINES = 1 << TAG_W;
  localparam int AGE_W  = $clog2(WINDOW + 1);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] held;
  logic [AGE_W-1:0] age  [DEPTH];
  logic [TAG_W-1:0] tag  [DEPTH];
  logic [LINE_W-1:0] qdat [DEPTH];
  logic [LINE_W-1:0] mem  [NLINES];
  logic              wait_v;
  logic [TAG_W-1:0]  wait_tag;

  logic [CNT_W-1:0] cnt;
  logic             free_ok, hit, ret;
  logic [IDX_W-1:0] free_idx, hit_idx, ret_idx;
  logic [AGE_W-1:0] best;

  wire [TAG_W-1:0] req_tag   = req_addr[ADDR_W-1:OFF];
  wire             lo_unused = ^req_addr[OFF-1:0];
  wire             rd_req    = req_valid & ~req_write;
  wire             wr_acc    = req_valid & req_write & req_ready;
  wire             fill      = dat_valid & wait_v & free_ok;

  always_comb begin
    cnt = '0; free_ok = 1'b0; free_idx = '0;
    hit = 1'b0; hit_idx = '0; best = '1;
    ret = 1'b0; ret_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (held[i]) cnt = cnt + CNT_W'(1);
      else if (!free_ok) begin free_ok = 1'b1; free_idx = IDX_W'(i); end
      if (held[i] && tag[i] == req_tag && (!hit || age[i] < best)) begin
        hit = 1'b1; hit_idx = IDX_W'(i); best = age[i];
      end
      if (held[i] && age[i] == AGE_W'(WINDOW)) begin
        ret = 1'b1; ret_idx = IDX_W'(i);
      end
    end
  end

  assign req_ready = ~wait_v & (cnt < CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= '0;
      wait_v    <= 1'b0;
      wait_tag  <= '0;
      rd_valid  <= 1'b0;
      rd_bypass <= 1'b0;
      for (int i = 0; i < DEPTH; i++) age[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (held[i]) age[i] <= age[i] + AGE_W'(1);
      if (ret) held[ret_idx] <= 1'b0;
      if (fill) begin
        held[free_idx] <= 1'b1;
        age[free_idx]  <= AGE_W'(1);
      end
      if (dat_valid) wait_v <= 1'b0;
      if (wr_acc) begin
        wait_v   <= 1'b1;
        wait_tag <= req_tag;
      end
      rd_valid  <= rd_req;
      rd_bypass <= rd_req & hit;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag[free_idx]  <= wait_tag;
      qdat[free_idx] <= dat_line;
    end
    if (ret) mem[tag[ret_idx]] <= qdat[ret_idx];
    if (rd_req) rd_data <= hit ? qdat[hit_idx] : mem[req_tag];
  end
endmodule

// File: rtl/line_wq_bypass_chk.sv
`timescale 1ns/1ps
module line_wq_bypass_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
)(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_ready,
  input logic             dat_valid,
  input logic             wait_v,
  input logic             rd_valid,
  input logic             rd_bypass,
  input logic [CNT_W-1:0] cnt
);
  // R2
  addr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_ready |=> !req_ready);
  // R2
  data_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_v && dat_valid |=> !wait_v);
  // R3
  stray_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_v && dat_valid |=> cnt <= $past(cnt));
  // R4
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> rd_valid);
  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);
  // R5
  bypass_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bypass |-> rd_valid);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
endmodule

bind line_wq_bypass line_wq_bypass_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_ready(req_ready), .dat_valid(dat_valid), .wait_v(wait_v),
  .rd_valid(rd_valid), .rd_bypass(rd_bypass), .cnt(cnt));

// File: tb/test_line_wq_bypass.sv
`timescale 1ns/1ps
module test_line_wq_bypass;
  localparam int AW = 10, DEPTH = 3, WINDOW = 6, NL = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, dat_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [255:0] dat_line = '0;
  logic req_ready, rd_valid, rd_bypass;
  logic [255:0] rd_data;

  int n_tests = 0, n_fail = 0, e = 0;
  bit done = 1'b0;

  logic [255:0] m_mem [NL];
  int           q_d [$];
  logic [4:0]   q_t [$];
  logic [255:0] q_v [$];
  bit           aw = 1'b0;
  logic [4:0]   aw_t = '0;

  line_wq_bypass #(.ADDR_W(AW), .LINE_BYTES(32), .DEPTH(DEPTH), .WINDOW(WINDOW)) i_line_wq_bypass (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .dat_valid(dat_valid),
    .dat_line(dat_line), .rd_valid(rd_valid), .rd_data(rd_data), .rd_bypass(rd_bypass));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [255:0] got, input logic [255:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [255:0] mk(input int s);
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = 32'(s) * 32'h9E3779B1 + 32'(k * 7919);
    return v;
  endfunction

  task automatic clr();
    req_valid = 0; req_write = 0; dat_valid = 0;
  endtask

  task automatic step(input string ctx);
    bit exp_rdy, ev, eb;
    logic [255:0] ed;
    logic [4:0] rt;
    int best;
    e++;
    exp_rdy = !aw && q_d.size() < DEPTH;
    chk({ctx, " R2 R10"}, "req_ready", 256'(req_ready), 256'(exp_rdy));
    rt = req_addr[9:5];
    ev = req_valid && !req_write;
    eb = 1'b0; ed = m_mem[rt]; best = -1;
    foreach (q_d[i]) if (q_t[i] == rt && q_d[i] > best) begin best = q_d[i]; eb = 1'b1; ed = q_v[i]; end
    for (int i = q_d.size() - 1; i >= 0; i--)
      if (e - q_d[i] == WINDOW) begin
        m_mem[q_t[i]] = q_v[i];
        q_d.delete(i); q_t.delete(i); q_v.delete(i);
      end
    if (dat_valid && aw) begin
      q_d.push_back(e); q_t.push_back(aw_t); q_v.push_back(dat_line); aw = 1'b0;
    end
    if (req_valid && req_write && exp_rdy) begin aw = 1'b1; aw_t = rt; end
    @(posedge clk); #2;
    chk({ctx, " R4"}, "rd_valid", 256'(rd_valid), 256'(ev));
    if (ev) begin
      chk({ctx, eb ? " R5 R8" : " R6 R7"}, "rd_bypass", 256'(rd_bypass), 256'(eb));
      chk({ctx, " R11"}, "rd_data", rd_data, ed);
    end
  endtask

  task automatic idle(input string c, input int n);
    clr();
    repeat (n) step(c);
  endtask

  task automatic wr_line(input int line, input int off, input logic [255:0] d, input string c);
    clr();
    while (!req_ready) step(c);
    req_valid = 1; req_write = 1; req_addr = AW'(line * 32 + off);
    step(c);
    clr(); dat_valid = 1; dat_line = d;
    step(c);
    clr();
  endtask

  task automatic rd(input int line, input int off, input string c);
    clr(); req_valid = 1; req_addr = AW'(line * 32 + off);
    step(c);
    clr();
  endtask

  initial begin
    for (int i = 0; i < NL; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 reset state
    chk("R1", "req_ready after reset", 256'(req_ready), 256'(1));
    chk("R1", "rd_valid after reset", 256'(rd_valid), 256'(0));

    for (int i = 0; i < NL; i++) wr_line(i, 0, mk(i + 100), "R11 init");
    idle("init", 10);

    // R5 / R6: window edge, one read per cycle after the data phase
    wr_line(5, 0, mk(555), "R5");
    for (int k = 1; k <= WINDOW + 2; k++) rd(5, 0, k <= WINDOW ? "R5" : "R6");
    idle("R6", 4);
    rd(5, 0, "R6");

    // R7: read while address waits, then read in the data-phase cycle
    idle("R7", 8);
    req_valid = 1; req_write = 1; req_addr = AW'(6 * 32);
    step("R7");
    rd(6, 0, "R7");
    req_valid = 1; req_write = 0; req_addr = AW'(6 * 32);
    dat_valid = 1; dat_line = mk(666);
    step("R7");
    rd(6, 0, "R5");
    idle("R6", 8);
    rd(6, 0, "R6");

    // R8: two queued writes to one line
    wr_line(9, 0, mk(901), "R8");
    wr_line(9, 0, mk(902), "R8");
    rd(9, 0, "R8");
    idle("R8", 8);
    rd(9, 0, "R6");

    // R9: byte offsets ignored
    wr_line(12, 5, mk(1212), "R9");
    rd(12, 31, "R9");
    idle("R9", 8);
    rd(12, 17, "R9");

    // R10: full queue drops a write address
    idle("R10", 8);
    wr_line(1, 0, mk(11), "R10");
    wr_line(2, 0, mk(22), "R10");
    wr_line(3, 0, mk(33), "R10");
    chk("R10", "req_ready when full", 256'(req_ready), 256'(0));
    req_valid = 1; req_write = 1; req_addr = AW'(4 * 32);
    step("R10");
    clr(); dat_valid = 1; dat_line = mk(44);
    step("R10");
    idle("R10", 10);
    rd(4, 0, "R10");

    // R3: stray data phase
    clr(); dat_valid = 1; dat_line = mk(999);
    step("R3");
    idle("R3", 10);
    rd(4, 0, "R3");
    chk("R3", "req_ready after stray data", 256'(req_ready), 256'(1));

    for (int n = 0; n < 400; n++) begin
      case ($urandom % 4)
        0: idle("mix", 1 + $urandom % 3);
        1: wr_line($urandom % 4, $urandom % 32, mk(2000 + n), "mix R11");
        2: rd($urandom % 4, $urandom % 32, "mix R5");
        default: begin
          clr(); req_valid = 1; req_addr = AW'($urandom % 128);
          dat_valid = 1; dat_line = mk(3000 + n);
          step("mix R3");
          clr();
        end
      endcase
    end
    idle("drain", 10);
    for (int i = 0; i < NL; i++) rd(i, 0, "R6 final");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R4 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule